// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block is the address engine of a single DMA channel. A transfer is a block of frames, and each frame is a run of elements. After a start strobe, the engine presents one read address, one write address and an element-size code for the current element. When the downstream datapath accepts that element, the engine moves to the next one. It counts elements within the frame and frames within the block, and it pulses progress events as the transfer moves forward. Bus signalling, data storage and request synchronisation are handled by other logic.

The source side and the destination side each have their own addressing mode and their own pair of signed index steps. One step applies between elements and the other between frames. Because the steps are signed, a transfer can walk forwards, hold still, skip over gaps, or walk backwards through memory. An abort ends the transfer at the next element acceptance. When the block finishes, the channel returns to idle.

Top module: `xfer_walk2d`

## Requirements
- R1: After reset, busy_o is low and all four event outputs are low.
- R2: A start_i pulse while idle, with non-zero element and frame counts, latches the whole configuration. From the next cycle, busy_o is high, rd_addr_o and wr_addr_o hold the two base addresses, and size_o holds the size code. A start_i while busy is ignored.
- R3: An element is accepted in a cycle where busy_o and ack_i are both high. After elem_cnt_i × frame_cnt_i acceptances, busy_o falls in the following cycle.
- R4: Mode code 0 (fixed) keeps that side's address unchanged for the whole transfer.
- R5: Mode code 1 (bump) adds the element width in bytes on every advance. Size code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes.
- R6: Mode code 2 (skip) adds width + element index − 1 at both element and frame advances. The index is a signed 16-bit value.
- R7: Mode code 3 (two-level skip) adds width + element index − 1 between elements and width + frame index − 1 between frames. Both indices are signed.
- R8: ev_half_o pulses one cycle after the acceptance of element number ⌊E/2⌋ (counted from 1) of each frame. It never pulses when E = 1.
- R9: ev_frame_o pulses one cycle after the last element of each frame is accepted. ev_block_o pulses together with the final ev_frame_o, in the same cycle in which busy_o is first low.
- R10: ev_last_frame_o pulses in the first cycle in which the first element of the last frame is presented. For a single-frame block, this is the cycle right after start.
- R11: abort_i while busy stops the transfer after the next accepted element, or after the same-cycle acceptance if ack_i is also high. No later event fires, and ev_last_frame_o is suppressed. abort_i while idle has no effect.
- R12: A start_i with a zero element count or a zero frame count is ignored, and busy_o stays low.
- R13: While busy and ack_i is low, both addresses hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe |
| abort_i | input | 1 | Stop request |
| ack_i | input | 1 | Current element accepted |
| src_base_i | input | ADDR_W | Source start address |
| dst_base_i | input | ADDR_W | Destination start address |
| elem_cnt_i | input | ECNT_W | Elements per frame |
| frame_cnt_i | input | FCNT_W | Frames per block |
| size_i | input | 2 | Element size code |
| src_mode_i | input | 2 | Source address mode |
| dst_mode_i | input | 2 | Destination address mode |
| src_eidx_i | input | IDX_W | Source element index (signed) |
| src_fidx_i | input | IDX_W | Source frame index (signed) |
| dst_eidx_i | input | IDX_W | Destination element index (signed) |
| dst_fidx_i | input | IDX_W | Destination frame index (signed) |
| busy_o | output | 1 | Transfer in progress, addresses valid |
| rd_addr_o | output | ADDR_W | Current read address |
| wr_addr_o | output | ADDR_W | Current write address |
| size_o | output | 2 | Latched element size code |
| ev_half_o | output | 1 | Half-frame event pulse |
| ev_frame_o | output | 1 | Frame-done event pulse |
| ev_last_frame_o | output | 1 | Last-frame-start event pulse |
| ev_block_o | output | 1 | Block-done event pulse |

## Verification
The base addresses, size code and busy flag appear one cycle after the start edge. Each address step, busy drop and event pulse appears one cycle after the edge that accepts the element causing it. The bench's reference model advances on that same edge from the inputs it sampled there. Every model value is then compared with the outputs on the following falling edge, so each result is checked in the exact cycle it is due, never earlier or later. Stall patterns (always accept, alternate, random, never) stretch these timings so that the hold and abort cases are exercised.

// File: rtl/xfer_walk2d_pkg.sv
package xfer_walk2d_pkg;

   typedef enum logic [1:0] {
      AM_FIXED = 2'd0,
      AM_BUMP  = 2'd1,
      AM_SKIP1 = 2'd2,
      AM_SKIP2 = 2'd3
   } amode_e;

   localparam logic [1:0] SZ_B8  = 2'd0;
   localparam logic [1:0] SZ_B16 = 2'd1;
   localparam logic [1:0] SZ_B32 = 2'd2;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_B8:   size_bytes = 3'd1;
         SZ_B16:  size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/xfer_walk2d_side.sv
module xfer_walk2d_side
   import xfer_walk2d_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [1:0]        mode_i,
   input  logic [IDX_W-1:0]  eidx_i,
   input  logic [IDX_W-1:0]  fidx_i,
   input  logic [1:0]        size_i,
   input  logic              step_elem_i,
   input  logic              step_frame_i,
   output logic [ADDR_W-1:0] addr_o
);

   amode_e            mode_q;
   logic [IDX_W-1:0]  eidx_q, fidx_q;
   logic [ADDR_W-1:0] addr_q, eidx_x, fidx_x, unit, step_e, step_f;

   generate
      if (IDX_W >= ADDR_W) begin : g_trunc
         assign eidx_x = eidx_q[ADDR_W-1:0];
         assign fidx_x = fidx_q[ADDR_W-1:0];
      end else begin : g_sext
         assign eidx_x = {{(ADDR_W-IDX_W){eidx_q[IDX_W-1]}}, eidx_q};
         assign fidx_x = {{(ADDR_W-IDX_W){fidx_q[IDX_W-1]}}, fidx_q};
      end
   endgenerate

   assign unit = ADDR_W'(size_bytes(size_i));

   always_comb begin
      case (mode_q)
         AM_FIXED: begin
            step_e = '0;
            step_f = '0;
         end
         AM_BUMP: begin
            step_e = unit;
            step_f = unit;
         end
         AM_SKIP1: begin
            step_e = unit + eidx_x - ADDR_W'(1);
            step_f = step_e;
         end
         default: begin
            step_e = unit + eidx_x - ADDR_W'(1);
            step_f = unit + fidx_x - ADDR_W'(1);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= AM_BUMP;
         eidx_q <= '0;
         fidx_q <= '0;
         addr_q <= '0;
      end else if (load_i) begin
         mode_q <= amode_e'(mode_i);
         eidx_q <= eidx_i;
         fidx_q <= fidx_i;
         addr_q <= base_i;
      end else if (step_frame_i) begin
         addr_q <= addr_q + step_f;
      end else if (step_elem_i) begin
         addr_q <= addr_q + step_e;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/xfer_walk2d_count.sv
module xfer_walk2d_count #(
   parameter int ECNT_W = 24,
   parameter int FCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ECNT_W-1:0] ecnt_i,
   input  logic [FCNT_W-1:0] fcnt_i,
   input  logic              next_elem_i,
   input  logic              next_frame_i,
   output logic              last_elem_o,
   output logic              last_frame_o,
   output logic              half_o,
   output logic              next_last_o
);

   logic [ECNT_W-1:0] ecnt_q, e_pos;
   logic [FCNT_W-1:0] fcnt_q, f_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt_q <= '0;
         fcnt_q <= '0;
         e_pos  <= '0;
         f_pos  <= '0;
      end else if (load_i) begin
         ecnt_q <= ecnt_i;
         fcnt_q <= fcnt_i;
         e_pos  <= '0;
         f_pos  <= '0;
      end else if (next_frame_i) begin
         e_pos  <= '0;
         f_pos  <= f_pos + FCNT_W'(1);
      end else if (next_elem_i) begin
         e_pos  <= e_pos + ECNT_W'(1);
      end
   end

   assign last_elem_o  = (e_pos == ecnt_q - ECNT_W'(1));
   assign last_frame_o = (f_pos == fcnt_q - FCNT_W'(1));
   assign half_o       = ((e_pos + ECNT_W'(1)) == (ecnt_q >> 1));
   assign next_last_o  = (({1'b0, f_pos} + (FCNT_W+1)'(2)) == {1'b0, fcnt_q});

endmodule

// File: rtl/xfer_walk2d.sv
module xfer_walk2d
   import xfer_walk2d_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int ECNT_W = 24,
   parameter int FCNT_W = 16,
   parameter int IDX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              ack_i,
   input  logic [ADDR_W-1:0] src_base_i,
   input  logic [ADDR_W-1:0] dst_base_i,
   input  logic [ECNT_W-1:0] elem_cnt_i,
   input  logic [FCNT_W-1:0] frame_cnt_i,
   input  logic [1:0]        size_i,
   input  logic [1:0]        src_mode_i,
   input  logic [1:0]        dst_mode_i,
   input  logic [IDX_W-1:0]  src_eidx_i,
   input  logic [IDX_W-1:0]  src_fidx_i,
   input  logic [IDX_W-1:0]  dst_eidx_i,
   input  logic [IDX_W-1:0]  dst_fidx_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [1:0]        size_o,
   output logic              ev_half_o,
   output logic              ev_frame_o,
   output logic              ev_last_frame_o,
   output logic              ev_block_o
);

   localparam int NSIDE = 2;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("xfer_walk2d: ADDR_W must be at least 8");
      end
      if (ECNT_W < 2 || FCNT_W < 2) begin : g_bad_cnt
         $error("xfer_walk2d: count widths must be at least 2");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("xfer_walk2d: IDX_W must be at least 2");
      end
   endgenerate

   logic busy_q, stop_pend_q;
   logic [1:0] size_q;
   logic ev_half_q, ev_frame_q, ev_lf_q, ev_blk_q;

   logic last_elem, last_frame, half_hit, next_last;
   logic go, acc, elem_end, frame_end, blk_end, stop_now;

   assign go        = start_i && !busy_q && (elem_cnt_i != '0) && (frame_cnt_i != '0);
   assign acc       = busy_q && ack_i;
   assign elem_end  = acc && !last_elem;
   assign frame_end = acc && last_elem && !last_frame;
   assign blk_end   = acc && last_elem && last_frame;
   assign stop_now  = acc && (stop_pend_q || abort_i);

   xfer_walk2d_count #(
      .ECNT_W(ECNT_W),
      .FCNT_W(FCNT_W)
   ) u_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (go),
      .ecnt_i       (elem_cnt_i),
      .fcnt_i       (frame_cnt_i),
      .next_elem_i  (elem_end),
      .next_frame_i (frame_end),
      .last_elem_o  (last_elem),
      .last_frame_o (last_frame),
      .half_o       (half_hit),
      .next_last_o  (next_last)
   );

   logic [NSIDE-1:0][ADDR_W-1:0] base_a, addr_a;
   logic [NSIDE-1:0][1:0]        mode_a;
   logic [NSIDE-1:0][IDX_W-1:0]  eidx_a, fidx_a;

   assign base_a = {dst_base_i, src_base_i};
   assign mode_a = {dst_mode_i, src_mode_i};
   assign eidx_a = {dst_eidx_i, src_eidx_i};
   assign fidx_a = {dst_fidx_i, src_fidx_i};

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         xfer_walk2d_side #(
            .ADDR_W(ADDR_W),
            .IDX_W (IDX_W)
         ) u_side (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (go),
            .base_i       (base_a[s]),
            .mode_i       (mode_a[s]),
            .eidx_i       (eidx_a[s]),
            .fidx_i       (fidx_a[s]),
            .size_i       (size_q),
            .step_elem_i  (elem_end),
            .step_frame_i (frame_end),
            .addr_o       (addr_a[s])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         stop_pend_q <= 1'b0;
         size_q      <= SZ_B32;
         ev_half_q   <= 1'b0;
         ev_frame_q  <= 1'b0;
         ev_lf_q     <= 1'b0;
         ev_blk_q    <= 1'b0;
      end else begin
         ev_half_q  <= acc && half_hit;
         ev_frame_q <= acc && last_elem;
         ev_blk_q   <= blk_end;
         ev_lf_q    <= (go && (frame_cnt_i == FCNT_W'(1)))
                    || (frame_end && next_last && !stop_pend_q && !abort_i);
         if (go) begin
            busy_q      <= 1'b1;
            stop_pend_q <= 1'b0;
            size_q      <= size_i;
         end else if (acc) begin
            if (blk_end || stop_now) busy_q <= 1'b0;
            stop_pend_q <= 1'b0;
         end else if (busy_q && abort_i) begin
            stop_pend_q <= 1'b1;
         end
      end
   end

   assign busy_o          = busy_q;
   assign rd_addr_o       = addr_a[0];
   assign wr_addr_o       = addr_a[1];
   assign size_o          = size_q;
   assign ev_half_o       = ev_half_q;
   assign ev_frame_o      = ev_frame_q;
   assign ev_last_frame_o = ev_lf_q;
   assign ev_block_o      = ev_blk_q;

endmodule

// File: rtl/xfer_walk2d_chk.sv
module xfer_walk2d_chk #(
   parameter int ADDR_W = 32,
   parameter int ECNT_W = 24,
   parameter int FCNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              ack_i,
   input logic [ECNT_W-1:0] elem_cnt_i,
   input logic [FCNT_W-1:0] frame_cnt_i,
   input logic              busy_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [1:0]        size_o,
   input logic              ev_half_o,
   input logic              ev_frame_o,
   input logic              ev_block_o
);

   a_r9_block_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      ev_block_o |-> (ev_frame_o && !busy_o));

   a_r13_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !ack_i) |=> ($stable(rd_addr_o) && $stable(wr_addr_o)));

   a_r2_size_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(size_o));

   a_r12_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && (elem_cnt_i == '0 || frame_cnt_i == '0)) |=> !busy_o);

   a_r3_drop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(ack_i));

   a_r8_half_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ev_half_o |-> $past(ack_i && busy_o));

endmodule

bind xfer_walk2d xfer_walk2d_chk #(
   .ADDR_W(ADDR_W),
   .ECNT_W(ECNT_W),
   .FCNT_W(FCNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .ack_i       (ack_i),
   .elem_cnt_i  (elem_cnt_i),
   .frame_cnt_i (frame_cnt_i),
   .busy_o      (busy_o),
   .rd_addr_o   (rd_addr_o),
   .wr_addr_o   (wr_addr_o),
   .size_o      (size_o),
   .ev_half_o   (ev_half_o),
   .ev_frame_o  (ev_frame_o),
   .ev_block_o  (ev_block_o)
);

// File: tb/xfer_walk2d_tb_top.sv
module xfer_walk2d_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, abort_i = 1'b0, ack_i = 1'b0;
   logic [31:0] src_base_i = '0, dst_base_i = '0;
   logic [23:0] elem_cnt_i = '0;
   logic [15:0] frame_cnt_i = '0;
   logic [1:0]  size_i = 2'd2, src_mode_i = 2'd1, dst_mode_i = 2'd1;
   logic [15:0] src_eidx_i = '0, src_fidx_i = '0, dst_eidx_i = '0, dst_fidx_i = '0;
   logic        busy_o, ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o;
   logic [31:0] rd_addr_o, wr_addr_o;
   logic [1:0]  size_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_walk2d dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .ack_i(ack_i),
      .src_base_i(src_base_i), .dst_base_i(dst_base_i),
      .elem_cnt_i(elem_cnt_i), .frame_cnt_i(frame_cnt_i), .size_i(size_i),
      .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i),
      .src_eidx_i(src_eidx_i), .src_fidx_i(src_fidx_i),
      .dst_eidx_i(dst_eidx_i), .dst_fidx_i(dst_fidx_i),
      .busy_o(busy_o), .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o), .size_o(size_o),
      .ev_half_o(ev_half_o), .ev_frame_o(ev_frame_o),
      .ev_last_frame_o(ev_last_frame_o), .ev_block_o(ev_block_o)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   int    cyc = 0;
   bit    cmp_en = 0;
   bit    done = 0;
   int    ack_mode = 0;
   string cur_req = "R3";

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_busy, m_stop, m_half, m_frame, m_blk, m_lf, stopping;
   int          m_e, m_f, m_E, m_F;
   logic [31:0] m_src, m_dst;
   logic [1:0]  m_sz, m_sm, m_dm;
   int          m_se, m_sf, m_de, m_df;

   function automatic int width_of(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
   endfunction

   function automatic int step_of(input logic [1:0] mode, input int ei, input int fi,
                                  input bit at_frame, input logic [1:0] c);
      int w = width_of(c);
      case (mode)
         2'd0:    return 0;
         2'd1:    return w;
         2'd2:    return w + ei - 1;
         default: return at_frame ? (w + fi - 1) : (w + ei - 1);
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_stop = 0; m_half = 0; m_frame = 0; m_blk = 0; m_lf = 0;
         m_sz = 2'd2;
      end else begin
         m_half = 0; m_frame = 0; m_blk = 0; m_lf = 0;
         if (m_busy) begin
            if (ack_i) begin
               stopping = m_stop || abort_i;
               if (m_e + 1 == (m_E / 2)) m_half = 1;
               if (m_e == m_E - 1) begin
                  m_frame = 1;
                  if (m_f == m_F - 1) begin
                     m_blk = 1;
                     m_busy = 0;
                  end else begin
                     m_f++;
                     m_e = 0;
                     m_src = m_src + 32'(step_of(m_sm, m_se, m_sf, 1, m_sz));
                     m_dst = m_dst + 32'(step_of(m_dm, m_de, m_df, 1, m_sz));
                     if (m_f == m_F - 1 && !stopping) m_lf = 1;
                  end
               end else begin
                  m_e++;
                  m_src = m_src + 32'(step_of(m_sm, m_se, m_sf, 0, m_sz));
                  m_dst = m_dst + 32'(step_of(m_dm, m_de, m_df, 0, m_sz));
               end
               if (stopping) m_busy = 0;
               m_stop = 0;
            end else if (abort_i) begin
               m_stop = 1;
            end
         end else if (start_i && elem_cnt_i != 0 && frame_cnt_i != 0) begin
            m_busy = 1; m_stop = 0; m_e = 0; m_f = 0;
            m_E = int'(elem_cnt_i); m_F = int'(frame_cnt_i);
            m_src = src_base_i; m_dst = dst_base_i; m_sz = size_i;
            m_sm = src_mode_i; m_dm = dst_mode_i;
            m_se = int'($signed(src_eidx_i)); m_sf = int'($signed(src_fidx_i));
            m_de = int'($signed(dst_eidx_i)); m_df = int'($signed(dst_fidx_i));
            if (m_F == 1) m_lf = 1;
         end
      end
      if (cyc >= WD_LIMIT && !done) begin
         n_errors++;
         $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R3", "busy", 32'(busy_o), 32'(m_busy));
         chk("R8", "half", 32'(ev_half_o), 32'(m_half));
         chk("R9", "frame", 32'(ev_frame_o), 32'(m_frame));
         chk("R9", "block", 32'(ev_block_o), 32'(m_blk));
         chk("R10", "lastframe", 32'(ev_last_frame_o), 32'(m_lf));
         if (m_busy) begin
            chk(cur_req, "rd_addr", rd_addr_o, m_src);
            chk(cur_req, "wr_addr", wr_addr_o, m_dst);
            chk("R2", "size", 32'(size_o), 32'(m_sz));
         end
      end
   end

   // acceptance pattern
   always @(negedge clk) begin
      case (ack_mode)
         0:       ack_i = 1'b1;
         1:       ack_i = ~ack_i;
         2:       ack_i = 1'($urandom % 2);
         default: ack_i = 1'b0;
      endcase
   end

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input int e, input int f,
                        input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                        input int se, input int sf, input int de, input int df);
      src_base_i = s; dst_base_i = d; elem_cnt_i = 24'(e); frame_cnt_i = 16'(f);
      size_i = sz; src_mode_i = sm; dst_mode_i = dm;
      src_eidx_i = 16'(se); src_fidx_i = 16'(sf); dst_eidx_i = 16'(de); dst_fidx_i = 16'(df);
   endtask

   task automatic launch();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "busy", 32'(busy_o), 0);
      chk("R1", "events", {28'd0, ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o}, 0);
      cmp_en = 1;

      cur_req = "R5"; ack_mode = 0;
      setup(32'h1000, 32'h8000, 4, 3, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      cur_req = "R5"; ack_mode = 1;
      setup(32'h2001, 32'h3003, 5, 2, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      setup(32'h4000, 32'h5000, 6, 2, 2'd1, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      setup(32'h4100, 32'h5100, 3, 2, 2'd3, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      cur_req = "R4"; ack_mode = 2;
      setup(32'hF000_0010, 32'h600, 4, 3, 2'd2, 2'd0, 2'd1, 9, 9, 0, 0); launch();
      cur_req = "R6"; ack_mode = 2;
      setup(32'h9000, 32'h100, 3, 3, 2'd2, 2'd2, 2'd2, -7, 0, 13, 0); launch();
      cur_req = "R7"; ack_mode = 0;
      setup(32'hA000, 32'hB000, 4, 4, 2'd1, 2'd3, 2'd3, 5, 100, 3, -20); launch();
      ack_mode = 2;
      setup(32'h0000_0004, 32'hFFFF_FFF0, 2, 3, 2'd0, 2'd3, 2'd3, -3, -200, 7, 1); launch();
      cur_req = "R8"; ack_mode = 0;
      setup(32'h10, 32'h20, 1, 1, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      setup(32'h10, 32'h20, 1, 3, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      setup(32'h10, 32'h20, 7, 1, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();

      // R12: zero counts ignored
      cur_req = "R12";
      setup(32'h10, 32'h20, 0, 3, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      chk("R12", "busy zero elem", 32'(busy_o), 0);
      setup(32'h10, 32'h20, 3, 0, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();
      chk("R12", "busy zero frame", 32'(busy_o), 0);

      // R11: abort while idle has no effect
      @(negedge clk) abort_i = 1'b1;
      @(negedge clk) abort_i = 1'b0;
      chk("R11", "idle abort busy", 32'(busy_o), 0);
      cur_req = "R11"; ack_mode = 0;
      setup(32'h300, 32'h400, 3, 2, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0); launch();

      // R11 + R13: abort while stalled, then release
      ack_mode = 3;
      setup(32'h700, 32'h900, 8, 3, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (2) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk) abort_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11", "busy held until acceptance", 32'(busy_o), 1);
      chk("R13", "rd hold", rd_addr_o, 32'h700);
      ack_mode = 0;
      @(negedge clk);
      @(negedge clk);
      chk("R11", "busy after abort", 32'(busy_o), 0);
      repeat (4) @(negedge clk);

      // R11: abort into the last frame suppresses the last-frame event
      ack_mode = 0;
      setup(32'h50, 32'h60, 2, 2, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      @(negedge clk) abort_i = 1'b1;
      @(negedge clk) abort_i = 1'b0;
      repeat (4) @(negedge clk);

      // R2: start while busy is ignored
      cur_req = "R2"; ack_mode = 1;
      setup(32'hC00, 32'hD00, 5, 2, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (3) @(negedge clk);
      setup(32'hEEE0, 32'hDDD0, 2, 1, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (2) @(negedge clk);

      cur_req = "R13"; ack_mode = 2;
      setup(32'h1234_0000, 32'h0, 6, 4, 2'd1, 2'd2, 2'd3, 4, 0, -2, 64); launch();

      done = 1;
      cmp_en = 0;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule